// File: doc/BRIEF.md
# Core Operating-State Controller

This block holds the operating state of a serial peripheral engine and the status that goes with it. Software moves the core among three states (reset, run and pause) by writing a state register. Each accepted request lowers a settle flag for a fixed number of cycles, and software polls that flag before it issues the next request. Leaving pause for reset needs a two-step unlock: two successive writes of a dedicated clear code. A single write of that code, or a direct request for reset, leaves the core in pause.

Around the state register the block keeps a software reset strobe, two banks of sticky status flags that are cleared by writing ones (error flags and operational flags), an enable mask for the error flags, and a level interrupt. It drives gating outputs to the data path. Serial shifting and FIFO draining are allowed only in run. Output-FIFO preloading is allowed in run and in pause. Each entry into reset gives a one-cycle flush pulse that clears the FIFOs and word counters, and it also clears every status flag.

The register interface is a single-cycle write port and a read port whose data is registered. A read returns the register contents as they stood before the clock edge that samples the read address.

Top module: `core_state_ctrl`

## Requirements
- R1: After reset the state field reads 0 (reset), the settle flag reads 1, all error and operational flags read 0, the interrupt is low, and both gating outputs are low.
- R2: The state register holds the current state in bits [1:0], coded reset = 0, run = 1, pause = 3. The value 2 is never held. From reset a request of 1 or 3 moves to run or pause. From run a request of 0 or 3 moves to reset or pause. From pause a request of 1 moves to run. Any other request leaves the state unchanged.
- R3: Bit 2 of the state register (also driven on `settle_ok`) goes low for exactly SETTLE_CYCLES cycles after each accepted state write or software reset. A state write made while it is low is ignored.
- R4: In pause, two accepted writes of code 2 with no other accepted state write between them move the core to reset. A single code-2 write leaves it in pause. A write of 0 in pause leaves it in pause. An accepted write of any other code cancels a pending first code-2 write.
- R5: Any write to the software-reset register (address 1) forces the state to reset, even while the settle flag is low, and starts a new settle window.
- R6: Error register (address 2): bit 5 is output over-run, bit 4 input under-run, bit 3 output under-run and bit 2 input over-run. Each is set by `err_evt[3:0]` (in that order, high to low) while the state is not reset. Writing a 1 to a bit clears it. A new event in the same cycle as its clear leaves the bit set.
- R7: Operational register (address 4): bit 11 is max-input-done, bit 10 max-output-done, bit 9 input service and bit 8 output service. They are set by `op_evt[3:0]` (high to low) while the state is not reset, and cleared by writing ones, with the same rules as R6.
- R8: `irq` is high one cycle after any error flag whose enable bit (address 3, bits 5..2) is set, or after either service flag (bit 9 or 8). The done flags (bits 11, 10) alone do not raise it.
- R9: Each entry into reset (an accepted request from run or pause, or a software reset) pulses `flush` for one cycle and clears all error and operational flags. Events that arrive while in reset set no flag.
- R10: `run_active` is high only in run. `preload_ok` is high in run and in pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 state, 1 software reset, 2 errors, 3 error enable, 4 operational) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| err_evt | input | 4 | Error event pulses from the data path |
| op_evt | input | 4 | Operational event pulses from the data path |
| settle_ok | output | 1 | High when no state transition is settling |
| run_active | output | 1 | Permits serial shifting and FIFO draining |
| preload_ok | output | 1 | Permits output-FIFO preloading |
| flush | output | 1 | One-cycle pulse that clears FIFOs and word counters |
| irq | output | 1 | Level interrupt |

## Verification
A wrong state encoding or a transition to the wrong state shows up one read later in bits [1:0] of the state register, and at once on `run_active` and `preload_ok`. An unlock bit that is not armed or cleared correctly leaves the core in pause, or lets it slip into reset, on the second or first clear write. The bench checks both cases right after the settle window. A settle counter that is off by a cycle changes the measured low time of `settle_ok`. A missing flag clear on reset entry shows on the first read of the flag registers after `flush`.

// File: rtl/core_state_pkg.sv
package core_state_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd3
  } core_state_e;

  localparam logic [1:0] CODE_CLEAR = 2'd2;

  localparam logic [ADDR_W-1:0] A_STATE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SWRST  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ERR    = 3'd2;
  localparam logic [ADDR_W-1:0] A_ERR_EN = 3'd3;
  localparam logic [ADDR_W-1:0] A_OP     = 3'd4;

  localparam int VALID_BIT = 2;
  localparam int ERR_LSB   = 2;
  localparam int OP_LSB    = 8;
  localparam int NFLAG     = 4;

endpackage

// File: rtl/core_settle_timer.sv
module core_settle_timer #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign settled = (cnt == '0);

  AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (rst)
    start |=> !settled); // R3
endmodule

// File: rtl/core_state_fsm.sv
module core_state_fsm
  import core_state_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_wr,
  input  logic [1:0]  req_code,
  input  logic        swrst,
  input  logic        settled,
  output core_state_e state,
  output logic        accept,
  output logic        enter_reset
);
  core_state_e nxt;
  logic        armed, armed_nxt;

  assign accept = req_wr && settled && !swrst;

  always_comb begin
    nxt       = state;
    armed_nxt = armed;
    if (swrst) begin
      nxt       = ST_RESET;
      armed_nxt = 1'b0;
    end else if (accept) begin
      armed_nxt = 1'b0;
      unique case (state)
        ST_RESET: begin
          if (req_code == 2'd1)      nxt = ST_RUN;
          else if (req_code == 2'd3) nxt = ST_PAUSE;
        end
        ST_RUN: begin
          if (req_code == 2'd0)      nxt = ST_RESET;
          else if (req_code == 2'd3) nxt = ST_PAUSE;
        end
        ST_PAUSE: begin
          if (req_code == 2'd1) nxt = ST_RUN;
          else if (req_code == CODE_CLEAR) begin
            if (armed) nxt = ST_RESET;
            else       armed_nxt = 1'b1;
          end
        end
        default: nxt = ST_RESET;
      endcase
    end
  end

  assign enter_reset = swrst || (accept && nxt == ST_RESET && state != ST_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RESET;
      armed <= 1'b0;
    end else begin
      state <= nxt;
      armed <= armed_nxt;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state != core_state_e'(CODE_CLEAR)); // R2
  AST_SWRST_WINS: assert property (@(posedge clk) disable iff (rst)
    swrst |=> state == ST_RESET); // R5
  AST_FIRST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (accept && state == ST_PAUSE && req_code == CODE_CLEAR && !armed) |=> state == ST_PAUSE); // R4
  AST_PAUSE_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (accept && state == ST_PAUSE && req_code == 2'd0) |=> state == ST_PAUSE); // R4
endmodule

// File: rtl/core_flag_bank.sv
module core_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_all,
  input  logic         capture_en,
  input  logic [N-1:0] evt,
  input  logic         w1c_wr,
  input  logic [N-1:0] w1c_mask,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear_all)            flags[i] <= 1'b0;
      else if (capture_en && evt[i])   flags[i] <= 1'b1;
      else if (w1c_wr && w1c_mask[i])  flags[i] <= 1'b0;
    end
  end

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!clear_all && !w1c_wr) |=> (flags & $past(flags)) == $past(flags)); // R6
endmodule

// File: rtl/core_state_ctrl.sv
module core_state_ctrl
  import core_state_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NFLAG-1:0]  err_evt,
  input  logic [NFLAG-1:0]  op_evt,
  output logic              settle_ok,
  output logic              run_active,
  output logic              preload_ok,
  output logic              flush,
  output logic              irq
);
  core_state_e      state;
  logic             accept, enter_reset, swrst;
  logic             wr_state, wr_err, wr_en_mask, wr_op;
  logic [NFLAG-1:0] err_flags, op_flags, err_mask;
  logic             unused_bits;

  assign wr_state   = wr_en && wr_addr == A_STATE;
  assign swrst      = wr_en && wr_addr == A_SWRST;
  assign wr_err     = wr_en && wr_addr == A_ERR;
  assign wr_en_mask = wr_en && wr_addr == A_ERR_EN;
  assign wr_op      = wr_en && wr_addr == A_OP;
  assign unused_bits = ^{wr_data[DATA_W-1:OP_LSB+NFLAG], wr_data[OP_LSB-1:ERR_LSB+NFLAG]};

  core_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(accept || swrst), .settled(settle_ok));

  core_state_fsm u_fsm (
    .clk(clk), .rst(rst), .req_wr(wr_state), .req_code(wr_data[1:0]),
    .swrst(swrst), .settled(settle_ok), .state(state),
    .accept(accept), .enter_reset(enter_reset));

  core_flag_bank #(.N(NFLAG)) u_err (
    .clk(clk), .rst(rst), .clear_all(enter_reset), .capture_en(state != ST_RESET),
    .evt(err_evt), .w1c_wr(wr_err), .w1c_mask(wr_data[ERR_LSB +: NFLAG]),
    .flags(err_flags));

  core_flag_bank #(.N(NFLAG)) u_op (
    .clk(clk), .rst(rst), .clear_all(enter_reset), .capture_en(state != ST_RESET),
    .evt(op_evt), .w1c_wr(wr_op), .w1c_mask(wr_data[OP_LSB +: NFLAG]),
    .flags(op_flags));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_mask <= '0;
      flush    <= 1'b0;
      irq      <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_en_mask) err_mask <= wr_data[ERR_LSB +: NFLAG];
      flush <= enter_reset;
      irq   <= |(err_flags & err_mask) || |op_flags[1:0];
      rd_data <= '0;
      unique case (rd_addr)
        A_STATE:  begin
          rd_data[1:0]      <= state;
          rd_data[VALID_BIT] <= settle_ok;
        end
        A_ERR:    rd_data[ERR_LSB +: NFLAG] <= err_flags;
        A_ERR_EN: rd_data[ERR_LSB +: NFLAG] <= err_mask;
        A_OP:     rd_data[OP_LSB +: NFLAG]  <= op_flags;
        default:  rd_data <= '0;
      endcase
    end
  end

  assign run_active = (state == ST_RUN);
  assign preload_ok = (state == ST_RUN) || (state == ST_PAUSE);

  AST_FLUSH_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    flush |-> (state == ST_RESET && err_flags == '0 && op_flags == '0)); // R9
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (flush && !$past(enter_reset, 1) ) |-> 1'b0); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(|(err_flags & err_mask)) || $past(|op_flags[1:0]))); // R8
  AST_RESET_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESET && $past(state) == ST_RESET) |-> (err_flags == '0 && op_flags == '0)); // R9
endmodule

// File: tb/core_state_ctrl_bench.sv
`timescale 1ns/1ps
module core_state_ctrl_bench;
  localparam int SET = 4;

  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [3:0]  err_evt = '0, op_evt = '0;
  logic        settle_ok, run_active, preload_ok, flush, irq;
  int          checks = 0, failures = 0;

  always #2 clk = ~clk;

  core_state_ctrl #(.SETTLE_CYCLES(SET)) u_core_state_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .err_evt(err_evt), .op_evt(op_evt),
    .settle_ok(settle_ok), .run_active(run_active), .preload_ok(preload_ok),
    .flush(flush), .irq(irq));

  // each entry: {requested code[1:0], expected state[1:0]}
  localparam logic [3:0] VEC [18] = '{
    {2'd1,2'd1}, {2'd3,2'd3}, {2'd1,2'd1}, {2'd0,2'd0}, {2'd3,2'd3}, {2'd2,2'd3},
    {2'd2,2'd0}, {2'd1,2'd1}, {2'd2,2'd1}, {2'd3,2'd3}, {2'd0,2'd3}, {2'd2,2'd3},
    {2'd1,2'd1}, {2'd3,2'd3}, {2'd2,2'd3}, {2'd3,2'd3}, {2'd2,2'd3}, {2'd2,2'd0}};

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a; tick(); v = rd_data;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic settle(); repeat (SET) tick(); endtask

  task automatic pulse_err(input logic [3:0] e); err_evt = e; tick(); err_evt = '0; endtask
  task automatic pulse_op(input logic [3:0] e);  op_evt = e;  tick(); op_evt = '0;  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int lowcnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, v); chk("R1 state", v, 32'h4);
    rd(3'd2, v); chk("R1 err", v, 32'h0);
    rd(3'd4, v); chk("R1 op", v, 32'h0);
    chk("R1 irq/gates", {irq, run_active, preload_ok, settle_ok}, 4'b0001);

    // R2 R4 transition table
    foreach (VEC[i]) begin
      wr(3'd0, {30'd0, VEC[i][3:2]});
      settle();
      rd(3'd0, v);
      chk($sformatf("R2 R4 step %0d", i), v, {29'd0, 1'b1, VEC[i][1:0]});
    end

    // R3 settle window length and ignored write
    wr(3'd0, 32'd1);
    lowcnt = 0;
    while (!settle_ok) begin lowcnt++; tick(); end
    chk("R3 low cycles", lowcnt, SET);
    wr(3'd0, 32'd3); wr(3'd0, 32'd0);   // second write lands in the low window
    settle();
    rd(3'd0, v); chk("R3 ignored write", v, 32'h7);

    // R5 software reset while settling
    wr(3'd0, 32'd1);
    wr(3'd1, 32'd1);
    chk("R5 state reset", {run_active, preload_ok, settle_ok}, 3'b000);
    settle();
    rd(3'd0, v); chk("R5 read", v, 32'h4);

    // R10 gating in each state
    chk("R10 reset gates", {run_active, preload_ok}, 2'b00);
    wr(3'd0, 32'd3); settle();
    chk("R10 pause gates", {run_active, preload_ok}, 2'b01);
    wr(3'd0, 32'd1); settle();
    chk("R10 run gates", {run_active, preload_ok}, 2'b11);

    // R6 error flags, W1C, set wins
    pulse_err(4'b1010);
    rd(3'd2, v); chk("R6 err set", v, 32'h28);
    wr(3'd2, 32'h20);
    rd(3'd2, v); chk("R6 w1c", v, 32'h08);
    err_evt = 4'b0001; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 32'h04;
    tick();
    err_evt = '0; wr_en = 1'b0; wr_data = '0;
    rd(3'd2, v); chk("R6 set wins", v, 32'h0C);

    // R8 interrupt from enabled errors
    chk("R8 masked", irq, 1'b0);
    wr(3'd3, 32'h3C); tick();
    chk("R8 enabled", irq, 1'b1);
    wr(3'd2, 32'h0C); tick();
    chk("R8 cleared", irq, 1'b0);

    // R7 operational flags
    pulse_op(4'b1100); tick();
    chk("R8 done no irq", irq, 1'b0);
    rd(3'd4, v); chk("R7 op set", v, 32'hC00);
    pulse_op(4'b0001); tick();
    chk("R8 service irq", irq, 1'b1);
    wr(3'd4, 32'h400);
    rd(3'd4, v); chk("R7 w1c", v, 32'h900);

    // R9 entry to reset clears and flushes
    pulse_err(4'b1000);
    wr(3'd0, 32'd0);
    chk("R9 flush pulse", flush, 1'b1);
    tick();
    chk("R9 flush single", flush, 1'b0);
    rd(3'd2, v); chk("R9 err cleared", v, 32'h0);
    rd(3'd4, v); chk("R9 op cleared", v, 32'h0);
    settle();
    pulse_err(4'b1111); pulse_op(4'b1111);
    rd(3'd2, v); chk("R9 err ignored in reset", v, 32'h0);
    rd(3'd4, v); chk("R9 op ignored in reset", v, 32'h0);
    tick();
    chk("R9 irq quiet", irq, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule